// File: doc/BRIEF.md
# Triggered DMA Channel with Optional Source Prefetch

This block is one data-moving channel. A descriptor, made of a nonzero pointer, an element count, source and destination base addresses and a few control bits, is loaded into the channel. Once the channel is enabled, it reads elements from the source side through a simple request/ready read port and stores them in a small internal FIFO. It then drains the FIFO to the destination through a request/ready write port. Destination writes never begin before a trigger pulse has been accepted. A per-descriptor prefetch bit chooses when source reads may start. With prefetch on, the FIFO fills ahead of the trigger, so the first write can issue in the cycle right after the trigger is sampled.

The element size is held apart from the bus transfer size on each side. A source word read of a narrow element drops the unused upper bits. A destination word write of a narrow element puts zeros in the upper bits. Size combinations that make no sense are reported on an error output and stop the channel from moving any data. When the last element has been written, the channel emits a one-cycle done pulse and releases the descriptor. If the descriptor's stop bit is set, the channel also switches itself off.

Top module: `dma_prefetch_channel`

## Requirements
- R1: With the prefetch bit clear, `rd_req` stays low until a trigger has been accepted while the channel is enabled.
- R2: With the prefetch bit set, source reads start once the channel is enabled, the descriptor pointer is nonzero and the FIFO has room. With no writes draining it, exactly DEPTH reads (default 4) complete before `rd_req` falls.
- R3: `wr_req` is never raised before a trigger is accepted. With prefetched data, `wr_req` is high in the first cycle after the trigger edge. Without prefetch, `wr_req` is still low in that cycle.
- R4: Size codes are 0 = 8-bit, 1 = 16-bit and 2 = 32-bit. `rd_size` and `wr_size` use the same code. A bus side that is not set to word transfers uses the element size.
- R5: When the source-word bit is 1, `rd_size` is 2 and the address advances by 4 per read. The element kept is the low 8 or 16 bits of `rd_data`. When the bit is 0, the address advances by the element size in bytes.
- R6: When the destination-word bit is 1, `wr_size` is 2 and the address advances by 4 per write. In every case the bits of `wr_data` above the element size are zero.
- R7: The legal settings are element 0 or 1 with any pair of word bits, and element 2 with both word bits set. Any other setting, or a count of zero, with a nonzero pointer raises `cfg_err`, and no read or write is issued.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of the write that completes the programmed count. It pulses once per descriptor.
- R9: If the descriptor stop bit is set, `ch_enabled` is low after `done`. Otherwise the channel stays enabled and idle until a new descriptor is loaded.
- R10: A trigger that arrives while the channel is disabled is dropped. Enabling the channel afterwards does not start a prefetch-off transfer.
- R11: Reads stall while the FIFO is full, and writes stall while it is empty. This holds even when a trigger is pending, and no element is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_set | input | 1 | Pulse that enables the channel |
| ch_enabled | output | 1 | Channel enable status |
| desc_load | input | 1 | Pulse that loads the descriptor fields below and clears progress |
| desc_ptr | input | PTR_W | Descriptor pointer; zero means no descriptor |
| desc_count | input | CNT_W | Number of elements to move |
| desc_src | input | ADDR_W | Source base address |
| desc_dst | input | ADDR_W | Destination base address |
| desc_elem | input | 2 | Element size code |
| desc_src_word | input | 1 | 1: source reads are 32-bit words |
| desc_dst_word | input | 1 | 1: destination writes are 32-bit words |
| desc_prefetch | input | 1 | 1: allow source reads before the trigger |
| desc_stop | input | 1 | 1: disable the channel when the descriptor completes |
| trig | input | 1 | Transfer trigger pulse |
| rd_req | output | 1 | Source read request |
| rd_addr | output | ADDR_W | Source read address |
| rd_size | output | 2 | Source bus transfer size code |
| rd_ready | input | 1 | Read accepted, with `rd_data` valid in the same cycle |
| rd_data | input | 32 | Source read data, right-aligned |
| wr_req | output | 1 | Destination write request |
| wr_addr | output | ADDR_W | Destination write address |
| wr_size | output | 2 | Destination bus transfer size code |
| wr_data | output | 32 | Destination write data, zero-extended |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | One-cycle descriptor completion pulse |
| cfg_err | output | 1 | Illegal size setting or zero count on a loaded descriptor |

## Verification
A stale or early trigger flag appears at the ports within one cycle, as a write request before the trigger or as a prefetch-off read before it. A wrong FIFO fill count changes how many reads complete ahead of the trigger, or makes the channel write data that was never read. Those cases are caught by the pre-trigger read count and by the first mismatched `wr_data`. An address or beat counter that slips shows up on the very next handshake as a wrong `rd_addr` or `wr_addr`. It can also show up as a `done` pulse that lands one write early or late.

// File: rtl/dmach_pkg.sv
// Shared size codes and helpers for the DMA channel.
// Assumes a 32-bit data bus on both the source and destination sides.
package dmach_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    // True when the element size and the two word bits form a legal setting.
    function automatic logic combo_legal(logic [1:0] elem, logic src_word, logic dst_word);
        case (elem)
            SZ_BYTE, SZ_HALF: return 1'b1;
            SZ_WORD:          return src_word && dst_word;
            default:          return 1'b0;
        endcase
    endfunction

    // Bit mask that keeps the element bits of a bus word.
    function automatic logic [BUS_W-1:0] elem_mask(logic [1:0] elem);
        case (elem)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Number of bytes covered by one transfer of the given size code.
    function automatic logic [2:0] size_bytes(logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmach_fifo.sv
// Element FIFO between the source and destination sides of the channel.
// Assumes the caller never pushes when full or pops when empty; flush empties it.
module dmach_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [CW-1:0]    fill;

    // Next slot index with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            if (push && !pop)      fill <= fill + 1'b1;
            else if (pop && !push) fill <= fill - 1'b1;
        end
    end

    // Data storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (push) store[wptr] <= din;
    end

    assign dout  = store[rptr];
    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);

    a_r11_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

endmodule

// File: rtl/dmach_sizer.sv
// Size conversion between element and bus transfer widths, and address steps.
// Assumes rd_data is right-aligned; truncation on read, zero extension on write.
module dmach_sizer
    import dmach_pkg::*;
(
    input  logic [1:0]       elem,
    input  logic             src_word,
    input  logic             dst_word,
    input  logic [BUS_W-1:0] rd_data,
    input  logic [BUS_W-1:0] head,
    output logic [1:0]       rd_size,
    output logic [1:0]       wr_size,
    output logic [2:0]       src_step,
    output logic [2:0]       dst_step,
    output logic             legal,
    output logic [BUS_W-1:0] rd_elem,
    output logic [BUS_W-1:0] wr_data
);
    logic [BUS_W-1:0] mask;

    // Derive bus sizes, steps and data conversions from the descriptor.
    always_comb begin
        mask     = elem_mask(elem);
        rd_size  = src_word ? SZ_WORD : elem;
        wr_size  = dst_word ? SZ_WORD : elem;
        src_step = size_bytes(rd_size);
        dst_step = size_bytes(wr_size);
        legal    = combo_legal(elem, src_word, dst_word);
        rd_elem  = rd_data & mask;
        wr_data  = head & mask;
    end

    // A legal 32-bit element must travel as words on both sides.
    always_comb begin
        if (legal && elem == SZ_WORD) begin
            a_r4_word_elem_word_bus: assert (rd_size == SZ_WORD && wr_size == SZ_WORD);
        end
    end

endmodule

// File: rtl/dmach_side.sv
// Address and beat counter for one bus side of the channel.
// Assumes load and fire never coincide; step is a byte count of 1, 2 or 4.
module dmach_side #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [2:0]        step,
    input  logic              fire,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  beats
);
    // Restart at the base on load, advance one transfer per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            beats <= '0;
        end else if (load) begin
            addr  <= base;
            beats <= '0;
        end else if (fire) begin
            addr  <= addr + ADDR_W'(step);
            beats <= beats + 1'b1;
        end
    end

endmodule

// File: rtl/dma_prefetch_channel.sv
// Single DMA channel: source reads into a FIFO, triggered destination writes.
// Assumes descriptors are loaded only when no transfer is in flight, and
// en_set is not pulsed in the cycle that completes a descriptor with stop set.
module dma_prefetch_channel
    import dmach_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    output logic              ch_enabled,
    input  logic              desc_load,
    input  logic [PTR_W-1:0]  desc_ptr,
    input  logic [CNT_W-1:0]  desc_count,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [1:0]        desc_elem,
    input  logic              desc_src_word,
    input  logic              desc_dst_word,
    input  logic              desc_prefetch,
    input  logic              desc_stop,
    input  logic              trig,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              done,
    output logic              cfg_err
);
    logic              en_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        elem_q;
    logic              sw_q;
    logic              dw_q;
    logic              pf_q;
    logic              stop_q;
    logic              trig_q;
    logic              done_q;

    logic [2:0]        src_step;
    logic [2:0]        dst_step;
    logic              legal;
    logic [BUS_W-1:0]  rd_elem;
    logic [BUS_W-1:0]  head;
    logic              fifo_full;
    logic              fifo_empty;
    logic [CNT_W-1:0]  rd_beats;
    logic [CNT_W-1:0]  wr_beats;
    logic              have_desc;
    logic              runnable;
    logic              rd_fire;
    logic              wr_fire;
    logic              last_wr;

    // Latch the descriptor fields; release the pointer on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cnt_q  <= '0;
            elem_q <= SZ_BYTE;
            sw_q   <= 1'b0;
            dw_q   <= 1'b0;
            pf_q   <= 1'b0;
            stop_q <= 1'b0;
        end else if (desc_load) begin
            ptr_q  <= desc_ptr;
            cnt_q  <= desc_count;
            elem_q <= desc_elem;
            sw_q   <= desc_src_word;
            dw_q   <= desc_dst_word;
            pf_q   <= desc_prefetch;
            stop_q <= desc_stop;
        end else if (last_wr) begin
            ptr_q  <= '0;
        end
    end

    // Channel enable: set by request, cleared by completion with stop set.
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_q <= 1'b0;
        else if (last_wr && stop_q) en_q <= 1'b0;
        else if (en_set)            en_q <= 1'b1;
    end

    // Trigger capture: only while enabled, dropped on load and completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                  trig_q <= 1'b0;
        else if (desc_load || last_wr) trig_q <= 1'b0;
        else if (en_q && trig)       trig_q <= 1'b1;
    end

    // Registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_wr;
    end

    // Request gating for both sides.
    always_comb begin
        have_desc = (ptr_q != '0);
        cfg_err   = have_desc && (!legal || cnt_q == '0);
        runnable  = en_q && have_desc && !cfg_err;
        rd_req    = runnable && (rd_beats < cnt_q) && !fifo_full && (pf_q || trig_q);
        wr_req    = runnable && trig_q && !fifo_empty;
        rd_fire   = rd_req && rd_ready;
        wr_fire   = wr_req && wr_ready;
        last_wr   = wr_fire && (wr_beats == cnt_q - 1'b1);
    end

    assign ch_enabled = en_q;
    assign done       = done_q;

    dmach_sizer u_sizer (
        .elem     (elem_q),
        .src_word (sw_q),
        .dst_word (dw_q),
        .rd_data  (rd_data),
        .head     (head),
        .rd_size  (rd_size),
        .wr_size  (wr_size),
        .src_step (src_step),
        .dst_step (dst_step),
        .legal    (legal),
        .rd_elem  (rd_elem),
        .wr_data  (wr_data)
    );

    dmach_fifo #(.DEPTH(DEPTH), .WIDTH(BUS_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (desc_load),
        .push  (rd_fire),
        .din   (rd_elem),
        .pop   (wr_fire),
        .dout  (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    dmach_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (desc_load),
        .base  (desc_src),
        .step  (src_step),
        .fire  (rd_fire),
        .addr  (rd_addr),
        .beats (rd_beats)
    );

    dmach_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (desc_load),
        .base  (desc_dst),
        .step  (dst_step),
        .fire  (wr_fire),
        .addr  (wr_addr),
        .beats (wr_beats)
    );

    a_r1_no_early_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_q && !trig_q) |-> !rd_req);
    a_r3_write_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> trig_q);
    a_r7_error_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!rd_req && !wr_req));
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_req && wr_ready));
    a_r9_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (last_wr && stop_q) |=> !ch_enabled);
    a_r10_trigger_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_enabled && !trig_q) |=> !trig_q);

endmodule

// File: tb/dma_prefetch_channel_test.sv
module dma_prefetch_channel_test;
    localparam int DEPTH = 4;
    localparam logic [31:0] SRC_BASE = 32'h1000_0100;
    localparam logic [31:0] DST_BASE = 32'h2000_0040;
    localparam int NROWS = 11;

    // Row: {elem[1:0], src_word, dst_word, prefetch, stop, count[7:0], err, pad}
    localparam logic [15:0] VEC [NROWS] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd6, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3, 1'b0, 1'b0},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd4, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd5, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd7, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 8'd6, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3, 1'b1, 1'b0},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 1'b0;
    logic        ch_enabled;
    logic        desc_load = 1'b0;
    logic [7:0]  desc_ptr = '0;
    logic [7:0]  desc_count = '0;
    logic [31:0] desc_src = '0;
    logic [31:0] desc_dst = '0;
    logic [1:0]  desc_elem = '0;
    logic        desc_src_word = 1'b0;
    logic        desc_dst_word = 1'b0;
    logic        desc_prefetch = 1'b0;
    logic        desc_stop = 1'b0;
    logic        trig = 1'b0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [1:0]  rd_size;
    logic        rd_ready = 1'b1;
    logic [31:0] rd_data;
    logic        wr_req;
    logic [31:0] wr_addr;
    logic [1:0]  wr_size;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        done;
    logic        cfg_err;

    int checks = 0, errs = 0, mon_checks = 0, mon_errs = 0;
    int rd_seen = 0, wr_seen = 0, done_seen = 0;
    int rd_base = 0, wr_base = 0, done_base = 0;
    int cur_elem = 0, cur_sw = 0, cur_dw = 0;
    int row_elem, row_sw, row_dw, row_pf, row_stop, row_cnt, row_err;

    always #10 clk = ~clk;

    dma_prefetch_channel #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .ch_enabled(ch_enabled),
        .desc_load(desc_load), .desc_ptr(desc_ptr), .desc_count(desc_count),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_elem(desc_elem),
        .desc_src_word(desc_src_word), .desc_dst_word(desc_dst_word),
        .desc_prefetch(desc_prefetch), .desc_stop(desc_stop), .trig(trig),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size), .rd_ready(rd_ready),
        .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ready(wr_ready), .done(done), .cfg_err(cfg_err)
    );

    // Source memory model: upper bytes nonzero so truncation is visible.
    function automatic logic [31:0] mem_word(logic [31:0] a);
        return {~a[7:0], 8'h96, a[7:0] ^ 8'h3C, a[15:8] + 8'h11};
    endfunction

    function automatic logic [31:0] mask_of(int e);
        return (e == 0) ? 32'hFF : (e == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int bytes_of(int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    assign rd_data = mem_word(rd_addr);

    // Bus monitor: checks every handshake against the requirement model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && rd_ready) begin
                int k, sz;
                logic [31:0] ea;
                k  = rd_seen - rd_base;
                sz = (cur_sw != 0) ? 2 : cur_elem;
                ea = SRC_BASE + 32'(k * bytes_of(sz));
                mon_checks++;
                if (rd_addr !== ea || rd_size !== 2'(sz)) begin
                    mon_errs++;
                    $display("FAIL R5 read %0d: addr %h size %0d, expected %h size %0d",
                             k, rd_addr, rd_size, ea, sz);
                end
                rd_seen++;
            end
            if (wr_req && wr_ready) begin
                int k, ssz, dsz;
                logic [31:0] ea, ed;
                k   = wr_seen - wr_base;
                ssz = (cur_sw != 0) ? 2 : cur_elem;
                dsz = (cur_dw != 0) ? 2 : cur_elem;
                ea  = DST_BASE + 32'(k * bytes_of(dsz));
                ed  = mem_word(SRC_BASE + 32'(k * bytes_of(ssz))) & mask_of(cur_elem);
                mon_checks++;
                if (wr_addr !== ea || wr_size !== 2'(dsz) || wr_data !== ed) begin
                    mon_errs++;
                    $display("FAIL R6 write %0d: addr %h size %0d data %h, expected %h size %0d data %h",
                             k, wr_addr, wr_size, wr_data, ea, dsz, ed);
                end
                wr_seen++;
            end
            if (done) done_seen++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(int ptr, int elem, int sw, int dw, int pf, int stop, int cnt);
        @(posedge clk); #1;
        desc_ptr = 8'(ptr); desc_count = 8'(cnt); desc_src = SRC_BASE; desc_dst = DST_BASE;
        desc_elem = 2'(elem); desc_src_word = 1'(sw); desc_dst_word = 1'(dw);
        desc_prefetch = 1'(pf); desc_stop = 1'(stop); desc_load = 1'b1;
        cur_elem = elem; cur_sw = sw; cur_dw = dw;
        rd_base = rd_seen; wr_base = wr_seen; done_base = done_seen;
        @(posedge clk); #1;
        desc_load = 1'b0;
    endtask

    task automatic pulse_en();
        @(posedge clk); #1; en_set = 1'b1;
        @(posedge clk); #1; en_set = 1'b0;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1; trig = 1'b1;
        @(posedge clk); #1; trig = 1'b0;
    endtask

    task automatic wait_done(int maxc);
        for (int i = 0; i < maxc && done_seen == done_base; i++) @(negedge clk);
        cycles(3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errs + mon_errs);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset ch_enabled", int'(ch_enabled), 0);
        chk("R1", "reset rd_req", int'(rd_req), 0);
        chk("R3", "reset wr_req", int'(wr_req), 0);
        chk("R8", "reset done", int'(done), 0);
        chk("R7", "reset cfg_err", int'(cfg_err), 0);

        // R10: trigger while disabled is not remembered.
        load(1, 2, 1, 1, 0, 1, 2);
        pulse_trig();
        pulse_en();
        cycles(6);
        chk("R10", "reads after disabled trigger", rd_seen - rd_base, 0);
        pulse_trig();
        wait_done(40);
        chk("R10", "writes after real trigger", wr_seen - wr_base, 2);
        chk("R9", "stop bit disables", int'(ch_enabled), 0);

        // Table of descriptor settings.
        for (int r = 0; r < NROWS; r++) begin
            row_elem = int'(VEC[r][15:14]); row_sw = int'(VEC[r][13]);
            row_dw = int'(VEC[r][12]); row_pf = int'(VEC[r][11]);
            row_stop = int'(VEC[r][10]); row_cnt = int'(VEC[r][9:2]);
            row_err = int'(VEC[r][1]);
            load(r + 2, row_elem, row_sw, row_dw, row_pf, row_stop, row_cnt);
            pulse_en();
            @(negedge clk);
            chk("R7", "cfg_err", int'(cfg_err), row_err);
            cycles(8);
            chk(row_pf != 0 ? "R2" : "R1", "reads before trigger", rd_seen - rd_base,
                (row_err == 0 && row_pf != 0) ? ((row_cnt < DEPTH) ? row_cnt : DEPTH) : 0);
            chk("R3", "writes before trigger", wr_seen - wr_base, 0);
            pulse_trig();
            @(negedge clk);
            chk("R3", "wr_req first cycle after trigger", int'(wr_req),
                (row_err == 0 && row_pf != 0) ? 1 : 0);
            if (row_err != 0) cycles(20);
            else wait_done(80);
            chk(row_err != 0 ? "R7" : "R4", "writes done", wr_seen - wr_base,
                row_err != 0 ? 0 : row_cnt);
            chk("R8", "done pulses", done_seen - done_base, row_err != 0 ? 0 : 1);
            chk("R9", "enable after descriptor", int'(ch_enabled),
                (row_err == 0 && row_stop != 0) ? 0 : 1);
        end

        // R11: full FIFO stalls reads; writes blocked by destination.
        wr_ready = 1'b0;
        load(20, 0, 0, 0, 1, 0, 8);
        pulse_en();
        cycles(8);
        @(negedge clk);
        chk("R11", "reads into full FIFO", rd_seen - rd_base, DEPTH);
        chk("R11", "rd_req when full", int'(rd_req), 0);
        pulse_trig();
        cycles(5);
        chk("R11", "writes while dest stalled", wr_seen - wr_base, 0);
        wr_ready = 1'b1;
        wait_done(60);
        chk("R11", "all writes after release", wr_seen - wr_base, 8);
        chk("R11", "all reads after release", rd_seen - rd_base, 8);

        // R11: empty FIFO blocks writes while reads are stalled.
        rd_ready = 1'b0;
        load(21, 1, 0, 1, 0, 0, 3);
        pulse_trig();
        cycles(4);
        @(negedge clk);
        chk("R11", "wr_req when empty", int'(wr_req), 0);
        chk("R1", "rd_req after trigger", int'(rd_req), 1);
        rd_ready = 1'b1;
        wait_done(40);
        chk("R11", "writes after read release", wr_seen - wr_base, 3);
        chk("R8", "done for stalled descriptor", done_seen - done_base, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks + mon_checks, errs + mon_errs);
        $finish;
    end

endmodule